// File: doc/BRIEF.md
# Port-Mapped I/O and Interrupt Latch Unit

This block sits on the I/O bus of an 8-bit CPU and answers port addresses in the 0xF0 to 0xFF window. Four read ports return groups of control-panel switches. One port exchanges bytes with an external disc player over a strobed byte bus. One port holds a general control byte. Two ports arm and disarm the interrupt latches.

A byte written to the player port is not sent at once. It waits as a pending command and goes onto the player bus when the player next asserts its command strobe. When the player asserts its status strobe, the byte on its bus is captured, and a read of the player port returns that byte. The maskable request is raised by a rising edge on a video timing input. The non-maskable request is raised by the falling (activating) edge of the status strobe. Each request has its own enable port. The strobes and the timing input are asynchronous, so each passes through a synchronizer before its edge is detected.

Top module: `io_port_unit`

## Requirements
- R1: A read (`io_rd_i`=1) of port 0xF0+n, for n = 0..3, returns panel group n (`panel_i[6n+5:6n]`) in data bits 5:0, with bits 7:6 driven to 0.
- R2: A read of port 0xF4 returns the `player_data_i` byte captured on the most recent falling edge of `stat_strobe_ni`. The value is 0x00 before any capture.
- R3: A write to 0xF4 leaves `player_data_o` unchanged. The pending byte appears on `player_data_o` SYNC_STAGES+1 clocks after a falling edge of `cmd_strobe_ni` is sampled, and it stays there until the next such edge.
- R4: If no write arrives between two command strobes, the same byte is sent again. A second write before the strobe replaces a pending byte that has not been sent.
- R5: After reset, both interrupt enables and both requests are 0, and the pending byte, `player_data_o`, the status byte and `misc_o` are all 0x00.
- R6: A write to 0xF5 stores the byte on `misc_o`. Reads of 0xF5, of unused addresses, and any cycle with `io_rd_i`=0 return 0x00.
- R7: A write to 0xFE with data bit 0 = 0 clears `irq_o` on the next clock and disables it. A write with bit 0 = 1 enables it without setting it. The other data bits are ignored.
- R8: A write to 0xFF with data bit 0 = 0 clears `nmi_o` on the next clock and disables it. A write with bit 0 = 1 enables it without setting it.
- R9: While enabled, a single 0-to-1 transition of `vsync_i` sets `irq_o` once, SYNC_STAGES+1 clocks after the new level is first sampled. `irq_o` then holds until a clearing write.
- R10: While enabled, a single 1-to-0 transition of `stat_strobe_ni` sets `nmi_o` once, with the same latency. `nmi_o` then holds until a clearing write. If the request is disabled, the edge is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe, one clock per write |
| io_rd_i | input | 1 | I/O read enable |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational |
| panel_i | input | 24 | Four 6-bit control-panel groups, group n at bits 6n+5:6n |
| cmd_strobe_ni | input | 1 | Player command strobe, asynchronous, active low |
| stat_strobe_ni | input | 1 | Player status strobe, asynchronous, active low |
| player_data_i | input | 8 | Byte from the player |
| player_data_o | output | 8 | Command byte presented to the player |
| vsync_i | input | 1 | Video timing signal, asynchronous |
| misc_o | output | 8 | General control byte |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the unit with its default parameters: four 6-bit panel groups and two synchronizer stages. Each strobe edge therefore takes effect exactly three clocks after the new level is sampled, and a reference model with a three-deep input history can follow it on every clock. With these values, a long strobe pulse can be shown to set a latch only once. The bench also covers an edge arriving while the latch is disabled, a latch that is re-armed with no fresh edge, and a pending byte that is overwritten before it is sent.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [7:0] PORT_PANEL0 = 8'hF0;
  localparam logic [7:0] PORT_PLAYER = 8'hF4;
  localparam logic [7:0] PORT_MISC   = 8'hF5;
  localparam logic [7:0] PORT_IRQ_EN = 8'hFE;
  localparam logic [7:0] PORT_NMI_EN = 8'hFF;
endpackage

// File: rtl/io_sync_edge.sv
module io_sync_edge #(
  parameter int unsigned STAGES = 2,
  parameter bit          IDLE   = 1'b0,
  parameter bit          RISE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {(STAGES+1){IDLE}};
    else         sr_q <= {sr_q[STAGES-1:0], async_i};
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sr_q[STAGES-1] & ~sr_q[STAGES];
    end else begin : g_fall
      assign edge_o = ~sr_q[STAGES-1] & sr_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/io_irq_latch.sv
module io_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic en_val_i,
  input  logic edge_i,
  output logic req_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      req_o <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_val_i;
      // clearing write wins over a coincident edge
      if (en_wr_i && !en_val_i)  req_o <= 1'b0;
      else if (en_q && edge_i)   req_o <= 1'b1;
    end
  end
endmodule

// File: rtl/io_player_port.sv
module io_player_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cmd_fire_i,
  input  logic         stat_fire_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      bus_o    <= '0;
      status_o <= '0;
    end else begin
      if (cmd_wr_i)    pend_q   <= wdata_i;
      if (cmd_fire_i)  bus_o    <= pend_q;
      if (stat_fire_i) status_o <= bus_i;
    end
  end
endmodule

// File: rtl/io_port_unit.sv
module io_port_unit
  import io_port_pkg::*;
#(
  parameter int unsigned PANEL_W     = 6,
  parameter int unsigned PANEL_PORTS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 io_addr_i,
  input  logic                       io_wr_i,
  input  logic                       io_rd_i,
  input  logic [DATA_W-1:0]          io_wdata_i,
  output logic [DATA_W-1:0]          io_rdata_o,
  input  logic [PANEL_PORTS*PANEL_W-1:0] panel_i,
  input  logic                       cmd_strobe_ni,
  input  logic                       stat_strobe_ni,
  input  logic [DATA_W-1:0]          player_data_i,
  output logic [DATA_W-1:0]          player_data_o,
  input  logic                       vsync_i,
  output logic [DATA_W-1:0]          misc_o,
  output logic                       irq_o,
  output logic                       nmi_o
);
  localparam int unsigned NCH = 3;
  // channel 0: command strobe, 1: status strobe, 2: video timing
  localparam logic [NCH-1:0] IDLE_VEC = 3'b011;
  localparam logic [NCH-1:0] RISE_VEC = 3'b100;

  logic [NCH-1:0] async_vec, edge_vec;
  logic           cmd_edge, stat_edge, irq_edge;
  logic [DATA_W-1:0] status_byte;
  logic [7:0]     panel_ofs;
  logic           wr_player, wr_misc, wr_irq, wr_nmi;

  assign async_vec = {vsync_i, stat_strobe_ni, cmd_strobe_ni};

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_sync
      io_sync_edge #(
        .STAGES (SYNC_STAGES),
        .IDLE   (IDLE_VEC[g]),
        .RISE   (RISE_VEC[g])
      ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (async_vec[g]),
        .edge_o  (edge_vec[g])
      );
    end
  endgenerate

  assign cmd_edge  = edge_vec[0];
  assign stat_edge = edge_vec[1];
  assign irq_edge  = edge_vec[2];

  assign wr_player = io_wr_i && (io_addr_i == PORT_PLAYER);
  assign wr_misc   = io_wr_i && (io_addr_i == PORT_MISC);
  assign wr_irq    = io_wr_i && (io_addr_i == PORT_IRQ_EN);
  assign wr_nmi    = io_wr_i && (io_addr_i == PORT_NMI_EN);

  io_player_port #(.W(DATA_W)) u_player (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_wr_i    (wr_player),
    .wdata_i     (io_wdata_i),
    .cmd_fire_i  (cmd_edge),
    .stat_fire_i (stat_edge),
    .bus_i       (player_data_i),
    .bus_o       (player_data_o),
    .status_o    (status_byte)
  );

  io_irq_latch u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (wr_irq),
    .en_val_i (io_wdata_i[0]),
    .edge_i   (irq_edge),
    .req_o    (irq_o)
  );

  io_irq_latch u_nmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (wr_nmi),
    .en_val_i (io_wdata_i[0]),
    .edge_i   (stat_edge),
    .req_o    (nmi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      misc_o <= '0;
    else if (wr_misc) misc_o <= io_wdata_i;
  end

  assign panel_ofs = io_addr_i - PORT_PANEL0;

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      if (io_addr_i == PORT_PLAYER) io_rdata_o = status_byte;
      for (int p = 0; p < PANEL_PORTS; p++) begin
        if (io_addr_i >= PORT_PANEL0 && panel_ofs == 8'(p))
          io_rdata_o = DATA_W'(panel_i[p*PANEL_W +: PANEL_W]);
      end
    end
  end
endmodule

// File: rtl/io_port_unit_chk.sv
module io_port_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] io_addr_i,
  input logic       io_wr_i,
  input logic       io_rd_i,
  input logic [7:0] io_wdata_i,
  input logic [7:0] io_rdata_o,
  input logic [7:0] player_data_o,
  input logic       irq_o,
  input logic       nmi_o,
  input logic       cmd_edge,
  input logic       stat_edge,
  input logic       irq_edge
);
  AST_PANEL_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i >= 8'hF0 && io_addr_i <= 8'hF3) |-> (io_rdata_o[7:6] == 2'b00)); // R1

  AST_PLAYER_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_edge |=> $stable(player_data_o)); // R3

  AST_IRQ_CLEAR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == 8'hFE && !io_wdata_i[0]) |=> !irq_o); // R7

  AST_NMI_CLEAR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == 8'hFF && !io_wdata_i[0]) |=> !nmi_o); // R8

  AST_IRQ_SET_BY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_edge)); // R9

  AST_NMI_SET_BY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(stat_edge)); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == 8'h00)); // R6
endmodule

bind io_port_unit io_port_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .io_addr_i     (io_addr_i),
  .io_wr_i       (io_wr_i),
  .io_rd_i       (io_rd_i),
  .io_wdata_i    (io_wdata_i),
  .io_rdata_o    (io_rdata_o),
  .player_data_o (player_data_o),
  .irq_o         (irq_o),
  .nmi_o         (nmi_o),
  .cmd_edge      (cmd_edge),
  .stat_edge     (stat_edge),
  .irq_edge      (irq_edge)
);

// File: tb/io_port_unit_tb.sv
module io_port_unit_tb;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 1'b0, rd = 1'b0;
  logic [23:0] panel = 24'h0;
  logic cmd_n = 1'b1, stat_n = 1'b1, vs = 1'b0;
  logic [7:0] pdata_in = 8'h00;
  logic [7:0] rdata, pdata_out, misc;
  logic irq, nmi;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  io_port_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .panel_i(panel),
    .cmd_strobe_ni(cmd_n), .stat_strobe_ni(stat_n), .player_data_i(pdata_in),
    .player_data_o(pdata_out), .vsync_i(vs), .misc_o(misc), .irq_o(irq), .nmi_o(nmi)
  );

  // reference model
  bit h_cmd[0:S], h_st[0:S], h_vs[0:S];
  logic [7:0] m_pend, m_out, m_stat, m_misc;
  bit m_irq, m_nmi, m_irq_en, m_nmi_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= S; i++) begin h_cmd[i] = 1; h_st[i] = 1; h_vs[i] = 0; end
      m_pend = 0; m_out = 0; m_stat = 0; m_misc = 0;
      m_irq = 0; m_nmi = 0; m_irq_en = 0; m_nmi_en = 0;
    end else begin
      bit f_cmd, f_st, r_vs;
      f_cmd = !h_cmd[S-1] && h_cmd[S];
      f_st  = !h_st[S-1]  && h_st[S];
      r_vs  =  h_vs[S-1]  && !h_vs[S];
      if (f_cmd) m_out = m_pend;
      if (wr && addr == 8'hF4) m_pend = wdata;
      if (f_st) m_stat = pdata_in;
      if (wr && addr == 8'hF5) m_misc = wdata;
      if (wr && addr == 8'hFE && !wdata[0]) m_irq = 0;
      else if (m_irq_en && r_vs) m_irq = 1;
      if (wr && addr == 8'hFF && !wdata[0]) m_nmi = 0;
      else if (m_nmi_en && f_st) m_nmi = 1;
      if (wr && addr == 8'hFE) m_irq_en = wdata[0];
      if (wr && addr == 8'hFF) m_nmi_en = wdata[0];
      for (int i = S; i > 0; i--) begin
        h_cmd[i] = h_cmd[i-1]; h_st[i] = h_st[i-1]; h_vs[i] = h_vs[i-1];
      end
      h_cmd[0] = cmd_n; h_st[0] = stat_n; h_vs[0] = vs;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (!rd) return 8'h00;
    if (addr >= 8'hF0 && addr <= 8'hF3) return {2'b00, panel[(addr-8'hF0)*6 +: 6]};
    if (addr == 8'hF4) return m_stat;
    return 8'h00;
  endfunction

  // compare on every clock, mid-cycle
  always @(posedge clk) begin
    cyc++;
    #5;
    if (rst_n) begin
      chk("R9/R7 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R10/R8 nmi", {7'b0, nmi}, {7'b0, m_nmi});
      chk("R3/R4 player_out", pdata_out, m_out);
      chk("R6 misc", misc, m_misc);
      if (rd && addr >= 8'hF0 && addr <= 8'hF3) chk("R1 panel read", rdata, exp_rd());
      else if (rd && addr == 8'hF4)             chk("R2 status read", rdata, exp_rd());
      else                                      chk("R6 idle/unused read", rdata, exp_rd());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_port(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_port(logic [7:0] a);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic cmd_pulse(int len);
    @(negedge clk); cmd_n = 0; idle(len); cmd_n = 1; idle(5);
  endtask

  task automatic stat_pulse(logic [7:0] d, int len);
    @(negedge clk); pdata_in = d; stat_n = 0; idle(len); stat_n = 1; idle(5);
  endtask

  task automatic vs_pulse(int len);
    @(negedge clk); vs = 1; idle(len); vs = 0; idle(5);
  endtask

  initial begin
    idle(3);
    // R5 reset state
    chk("R5 irq reset", {7'b0, irq}, 8'h00);
    chk("R5 nmi reset", {7'b0, nmi}, 8'h00);
    chk("R5 player_out reset", pdata_out, 8'h00);
    chk("R5 misc reset", misc, 8'h00);
    rst_n = 1;
    idle(2);
    rd_port(8'hF4);                    // R2 before capture: 0x00
    // R1 panel patterns
    panel = {6'h3F, 6'h00, 6'h2A, 6'h15};
    for (int p = 0; p < 4; p++) rd_port(8'hF0 + 8'(p));
    panel = {6'h01, 6'h20, 6'h3F, 6'h3E};
    for (int p = 0; p < 4; p++) rd_port(8'hF0 + 8'(p));
    // R6
    wr_port(8'hF5, 8'hA5);
    rd_port(8'hF5); rd_port(8'hF8); rd_port(8'hEF);
    // R3 queued command
    wr_port(8'hF4, 8'h3C);
    idle(3);
    chk("R3 write not sent", pdata_out, 8'h00);
    cmd_pulse(4);
    chk("R3 sent on strobe", pdata_out, 8'h3C);
    cmd_pulse(2);                      // R4 resend
    chk("R4 resend", pdata_out, 8'h3C);
    wr_port(8'hF4, 8'h11); wr_port(8'hF4, 8'h22);
    cmd_pulse(3);
    chk("R4 overwrite", pdata_out, 8'h22);
    // R10 disabled status strobe: capture only
    stat_pulse(8'h5A, 4);
    chk("R10 disabled nmi", {7'b0, nmi}, 8'h00);
    rd_port(8'hF4);
    // R8/R10 enable, single edge
    wr_port(8'hFF, 8'h01);
    idle(2);
    chk("R8 enable no set", {7'b0, nmi}, 8'h00);
    stat_pulse(8'h77, 10);
    chk("R10 nmi set", {7'b0, nmi}, 8'h01);
    rd_port(8'hF4);
    wr_port(8'hFF, 8'hFE);             // bit0=0 clears
    chk("R8 nmi cleared", {7'b0, nmi}, 8'h00);
    stat_pulse(8'h12, 3);
    chk("R8 held clear", {7'b0, nmi}, 8'h00);
    wr_port(8'hFF, 8'h01);
    idle(4);
    chk("R10 no stale edge", {7'b0, nmi}, 8'h00);
    stat_pulse(8'h99, 2);
    chk("R10 nmi reset by edge", {7'b0, nmi}, 8'h01);
    // R7/R9 irq
    vs_pulse(3);
    chk("R9 disabled irq", {7'b0, irq}, 8'h00);
    wr_port(8'hFE, 8'hF1);
    vs_pulse(12);
    chk("R9 irq set", {7'b0, irq}, 8'h01);
    wr_port(8'hFE, 8'h00);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);
    wr_port(8'hFE, 8'h01);
    idle(6);
    chk("R9 single edge once", {7'b0, irq}, 8'h00);
    vs_pulse(1);
    chk("R9 irq again", {7'b0, irq}, 8'h01);
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule